// File: doc/BRIEF.md
# Interrupt Recognition and Acknowledge Unit

This unit stands between one external interrupt request line and the sequence controller of a processor. It brings the raw line into the clock domain and recognizes a request according to a programmed trigger mode: high level, low level, rising edge or falling edge. Each recognized request is held in a request flag until the processor accepts it.

The request flag is gated by a global enable flag before it reaches the sequencer. The sequencer controls the enable flag with three single-cycle commands: enable, disable and return-from-interrupt. The unit issues an acknowledge only when the sequencer reports that an instruction has finished while a gated request is present. The acknowledge clears both flags. As a result, a request that arrives during a service routine waits in the request flag. It is offered to the sequencer in the first cycle after return-from-interrupt sets the enable flag again.

Top module: `irq_ack_unit`

## Requirements
- R1: `trig_mode` selects how a request is recognized: 2'b00 active-low level, 2'b01 active-high level, 2'b10 rising edge, 2'b11 falling edge. An input change that does not match the mode sets no request.
- R2: A matching change on `irq_raw`, sampled at a rising clock edge, shows on `pending` after the third rising edge counted from that edge, and not before.
- R3: In the edge modes, `pending` stays set after `irq_raw` returns to its idle value and is cleared only by an acknowledge.
- R4: `irq_to_seq` is high exactly when `pending` and `enabled` are both high.
- R5: `enabled` clears on reset, on a disable command, and on an acknowledge. A disable command takes precedence over an enable or return command in the same cycle.
- R6: An enable command or a return-from-interrupt command sets `enabled` at the next clock edge.
- R7: `irq_ack` is a one-cycle pulse. It is asserted at the edge after a cycle in which `instr_done` and `irq_to_seq` were both high, and never otherwise. In an edge mode with no new edge, the acknowledge leaves `pending` low.
- R8: If a request becomes pending while `enabled` is low, `irq_to_seq` rises in the cycle right after the return-from-interrupt command.
- R9: A request edge recognized at the same clock edge as an acknowledge is kept: `pending` is high after that edge.
- R10: After reset, `pending`, `enabled`, `irq_ack` and `irq_to_seq` are all low, and the idle input level is high.
- R11: In a level mode, an acknowledge that happens while the active level is still present leaves `pending` set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_raw | input | 1 | Asynchronous interrupt request line |
| trig_mode | input | 2 | Trigger mode selection (see R1) |
| instr_done | input | 1 | Current instruction finishes this cycle |
| ei_pulse | input | 1 | Enable-interrupts command |
| di_pulse | input | 1 | Disable-interrupts command |
| reti_pulse | input | 1 | Return-from-interrupt command |
| irq_to_seq | output | 1 | Gated request to the sequence controller |
| irq_ack | output | 1 | Acknowledge pulse to the device |
| pending | output | 1 | Request flag status |
| enabled | output | 1 | Global enable flag status |

## Verification
A change on `irq_raw` passes two synchronizer flops and then the request flag, so `pending` is due after the third rising edge. The bench samples one edge earlier to confirm the line is still low, then samples again at the due edge. The enable flag and the acknowledge each change one edge after their command or `instr_done` cycle, and `irq_to_seq` follows combinationally. For that reason every check is taken at the falling edge that follows the relevant rising edge. The coincident-edge case times `instr_done` to line up with the edge at which the detector fires. That is the second rising edge after the input change.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

    typedef enum logic [1:0] {
        TRIG_LOW_LEVEL  = 2'b00,
        TRIG_HIGH_LEVEL = 2'b01,
        TRIG_RISE_EDGE  = 2'b10,
        TRIG_FALL_EDGE  = 2'b11
    } trig_mode_e;

    typedef struct packed {
        logic req;
        logic en;
    } irq_flags_t;

    typedef struct packed {
        logic set_en;
        logic clr_en;
    } en_cmd_t;

    localparam logic IDLE_LEVEL_DEFAULT = 1'b1;

    function automatic logic is_edge_mode(input trig_mode_e m);
        return (m == TRIG_RISE_EDGE) || (m == TRIG_FALL_EDGE);
    endfunction

    function automatic logic active_level(input trig_mode_e m);
        return (m == TRIG_HIGH_LEVEL) || (m == TRIG_RISE_EDGE);
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int   STAGES   = 2,
    parameter logic RST_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    generate
        for (genvar i = 0; i <= LAST; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_LEVEL;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= RST_LEVEL;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[LAST];
endmodule

// File: rtl/irq_detect.sv
module irq_detect
    import irq_ack_pkg::*;
#(
    parameter logic RST_LEVEL = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       synced,
    input  trig_mode_e mode,
    output logic       hit
);
    logic prev_q;
    logic want;
    logic level_hit;
    logic edge_hit;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_LEVEL;
        else     prev_q <= synced;
    end

    always_comb begin
        want      = active_level(mode);
        level_hit = (synced == want);
        edge_hit  = (synced == want) && (prev_q != want);
        hit       = is_edge_mode(mode) ? edge_hit : level_hit;
    end
endmodule

// File: rtl/irq_flags.sv
module irq_flags
    import irq_ack_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hit,
    input  logic       take,
    input  en_cmd_t    cmd,
    output irq_flags_t flags
);
    irq_flags_t flags_q;
    irq_flags_t flags_d;

    always_comb begin
        flags_d = flags_q;
        // request flag: a new detection outranks the clearing acknowledge
        if (hit)       flags_d.req = 1'b1;
        else if (take) flags_d.req = 1'b0;
        // enable flag: clearing outranks setting
        if (cmd.clr_en || take) flags_d.en = 1'b0;
        else if (cmd.set_en)    flags_d.en = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    assign flags = flags_q;
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
    import irq_ack_pkg::*;
#(
    parameter int   SYNC_STAGES = 2,
    parameter logic IDLE_LEVEL  = IDLE_LEVEL_DEFAULT
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       irq_raw,
    input  logic [1:0] trig_mode,
    input  logic       instr_done,
    input  logic       ei_pulse,
    input  logic       di_pulse,
    input  logic       reti_pulse,
    output logic       irq_to_seq,
    output logic       irq_ack,
    output logic       pending,
    output logic       enabled
);
    logic       synced;
    logic       hit;
    logic       gated;
    logic       take;
    logic       ack_q;
    trig_mode_e mode;
    en_cmd_t    cmd;
    irq_flags_t flags;

    assign mode = trig_mode_e'(trig_mode);

    irq_sync #(
        .STAGES   (SYNC_STAGES),
        .RST_LEVEL(IDLE_LEVEL)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din (irq_raw),
        .dout(synced)
    );

    irq_detect #(
        .RST_LEVEL(IDLE_LEVEL)
    ) u_detect (
        .clk   (clk),
        .rst   (rst),
        .synced(synced),
        .mode  (mode),
        .hit   (hit)
    );

    always_comb begin
        cmd.set_en = ei_pulse || reti_pulse;
        cmd.clr_en = di_pulse;
    end

    assign gated = flags.req && flags.en;
    assign take  = gated && instr_done;

    irq_flags u_flags (
        .clk  (clk),
        .rst  (rst),
        .hit  (hit),
        .take (take),
        .cmd  (cmd),
        .flags(flags)
    );

    always_ff @(posedge clk) begin
        if (rst) ack_q <= 1'b0;
        else     ack_q <= take;
    end

    assign irq_to_seq = gated;
    assign irq_ack    = ack_q;
    assign pending    = flags.req;
    assign enabled    = flags.en;
endmodule

// File: rtl/irq_ack_unit_chk.sv
module irq_ack_unit_chk (
    input logic clk,
    input logic rst,
    input logic instr_done,
    input logic di_pulse,
    input logic reti_pulse,
    input logic ei_pulse,
    input logic irq_to_seq,
    input logic irq_ack,
    input logic pending,
    input logic enabled
);
    // R4
    gate_and_chk: assert property (@(posedge clk) disable iff (rst)
        irq_to_seq == (pending && enabled));

    // R7
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> !irq_ack);

    // R7
    ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_ack) |-> $past(instr_done && irq_to_seq));

    // R5
    ack_clears_en_chk: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> !enabled);

    // R5
    disable_wins_chk: assert property (@(posedge clk) disable iff (rst)
        di_pulse |=> !enabled);

    // R6
    enable_set_chk: assert property (@(posedge clk) disable iff (rst)
        ((ei_pulse || reti_pulse) && !di_pulse && !(instr_done && irq_to_seq)) |=> enabled);
endmodule

bind irq_ack_unit irq_ack_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .instr_done(instr_done),
    .di_pulse  (di_pulse),
    .reti_pulse(reti_pulse),
    .ei_pulse  (ei_pulse),
    .irq_to_seq(irq_to_seq),
    .irq_ack   (irq_ack),
    .pending   (pending),
    .enabled   (enabled)
);

// File: tb/tb_irq_ack_unit.sv
module tb_irq_ack_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       irq_raw = 1'b1;
    logic [1:0] trig_mode = 2'b00;
    logic       instr_done = 1'b0;
    logic       ei_pulse = 1'b0;
    logic       di_pulse = 1'b0;
    logic       reti_pulse = 1'b0;
    logic       irq_to_seq, irq_ack, pending, enabled;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_ack_unit dut (
        .clk(clk), .rst(rst), .irq_raw(irq_raw), .trig_mode(trig_mode),
        .instr_done(instr_done), .ei_pulse(ei_pulse), .di_pulse(di_pulse),
        .reti_pulse(reti_pulse), .irq_to_seq(irq_to_seq), .irq_ack(irq_ack),
        .pending(pending), .enabled(enabled)
    );

    // {mode[1:0], from, to, expected pending}
    localparam logic [4:0] VEC [8] = '{
        {2'b00, 1'b1, 1'b0, 1'b1},
        {2'b00, 1'b1, 1'b1, 1'b0},
        {2'b01, 1'b0, 1'b1, 1'b1},
        {2'b01, 1'b0, 1'b0, 1'b0},
        {2'b10, 1'b0, 1'b1, 1'b1},
        {2'b10, 1'b1, 1'b0, 1'b0},
        {2'b11, 1'b1, 1'b0, 1'b1},
        {2'b11, 1'b0, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic flush();
        step(4);
        ei_pulse = 1'b1;   step(1);
        ei_pulse = 1'b0;   instr_done = 1'b1; step(1);
        instr_done = 1'b0; di_pulse = 1'b1;   step(1);
        di_pulse = 1'b0;   step(1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R10 reset state
        check("R10 pending", pending, 1'b0);
        check("R10 enabled", enabled, 1'b0);
        check("R10 ack", irq_ack, 1'b0);
        check("R10 to_seq", irq_to_seq, 1'b0);

        // R1 / R2 vector table
        for (int i = 0; i < 8; i++) begin
            trig_mode = VEC[i][4:3];
            irq_raw   = VEC[i][2];
            flush();
            check("R1 cleared", pending, 1'b0);
            irq_raw = VEC[i][1];
            step(2);
            check("R2 early", pending, 1'b0);
            step(1);
            check("R1 pending", pending, VEC[i][0]);
        end

        // R3 edge held, R4 gating
        trig_mode = 2'b11; irq_raw = 1'b1; flush();
        irq_raw = 1'b0; step(1); irq_raw = 1'b1; step(5);
        check("R3 held", pending, 1'b1);
        check("R4 gated off", irq_to_seq, 1'b0);
        ei_pulse = 1'b1; step(1); ei_pulse = 1'b0;
        check("R6 enable", enabled, 1'b1);
        check("R4 gated on", irq_to_seq, 1'b1);
        // R7 no ack without instr_done
        step(3);
        check("R7 no ack", irq_ack, 1'b0);
        instr_done = 1'b1; step(1); instr_done = 1'b0;
        check("R7 ack", irq_ack, 1'b1);
        check("R7 pending cleared", pending, 1'b0);
        check("R5 ack clears en", enabled, 1'b0);
        step(1);
        check("R7 ack one cycle", irq_ack, 1'b0);

        // R8 request during service, presented after return
        irq_raw = 1'b0; step(4); irq_raw = 1'b1;
        check("R8 pending", pending, 1'b1);
        check("R8 masked", irq_to_seq, 1'b0);
        reti_pulse = 1'b1; step(1); reti_pulse = 1'b0;
        check("R8 presented", irq_to_seq, 1'b1);

        // R9 edge coinciding with acknowledge
        step(3);
        irq_raw = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        instr_done = 1'b1; step(1); instr_done = 1'b0;
        check("R9 ack", irq_ack, 1'b1);
        check("R9 pending kept", pending, 1'b1);
        irq_raw = 1'b1;

        // R5 disable wins
        ei_pulse = 1'b1; di_pulse = 1'b1; step(1);
        ei_pulse = 1'b0; di_pulse = 1'b0;
        check("R5 disable wins", enabled, 1'b0);
        reti_pulse = 1'b1; step(1); reti_pulse = 1'b0;
        check("R6 reti sets", enabled, 1'b1);
        di_pulse = 1'b1; step(1); di_pulse = 1'b0;
        check("R5 disable", enabled, 1'b0);

        // R11 level held across acknowledge
        trig_mode = 2'b00; irq_raw = 1'b0; step(4);
        ei_pulse = 1'b1; step(1); ei_pulse = 1'b0;
        instr_done = 1'b1; step(1); instr_done = 1'b0;
        check("R11 ack", irq_ack, 1'b1);
        check("R11 still pending", pending, 1'b1);
        irq_raw = 1'b1;

        // R10 reset mid-run
        rst = 1'b1; step(1); rst = 1'b0; step(1);
        check("R10 reset pending", pending, 1'b0);
        check("R10 reset enabled", enabled, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule